// File: doc/BRIEF.md
# Register Stack Frame Engine

This block keeps procedure register frames in a circular physical register file of 64 entries. A frame base pointer locates the current frame. A rename port turns a virtual register number into a physical index by adding it to the base, modulo the file size. Three commands maintain the frames. A call opens an empty frame for the callee directly above the caller's frame. An allocate sets how many registers the current frame needs. A return gives the caller back its own base and frame size.

When an allocate needs more registers than are free, the block raises stall. It then writes the oldest resident caller registers out to a backing store until enough entries are free. When a return finds that part of the caller's frame has been written out, it stalls and reads those registers back. Each transfer moves one register over a valid/ready request port. The block gives the physical index and the backing-store slot; the register datapath moves the data. A request stays asserted with every field unchanged until the responder takes it with ready. A low ready only delays the sequence and never changes its order. Software never saves or restores registers at procedure boundaries. Only the frame sizes carried by the commands start these transfers.

Saved caller base and size pairs are held in an 8-deep stack. A call that finds this stack full sets the error pulse and is dropped. A return that finds the stack empty does the same.

Top module: `rse_engine`

## Requirements
- R1: After reset, stall, err and mem_valid are low, the base is 0 and the current frame is empty, so every lookup misses.
- R2: lk_preg equals (base + lk_vreg) mod 64. lk_hit is high only when lk_vreg is below the current frame size and stall is low.
- R3: A call (cmd_op = 1) moves the base up by the caller's frame size, modulo 64, and sets the frame size to 0. It raises neither stall nor a memory request.
- R4: An allocate (cmd_op = 2) with cmd_size no larger than the free registers sets the frame size to cmd_size without stalling. A cmd_size above 64 counts as 64.
- R5: An allocate that asks for more than the free registers raises stall in the next cycle. It then spills exactly (request + resident caller registers - 64) registers with mem_write = 1. It starts at the oldest resident caller register, base minus resident count, and goes upward in physical index. The store slot starts at the current store top and goes upward.
- R6: While stall is high, every lookup misses and every command is ignored.
- R7: mem_valid is high for the whole transfer sequence. A request with mem_ready low keeps mem_addr, mem_preg and mem_write unchanged. Each handshake (mem_valid and mem_ready high together) moves exactly one register.
- R8: A return (cmd_op = 3) restores the caller's base and frame size. If every caller register is still resident, it does so without stalling or making a memory request.
- R9: A return whose caller frame has D spilled registers stalls and fills D registers with mem_write = 0. It fills in reverse spill order: physical index descends from (caller base + D - 1) mod 64, and the store slot descends from the store top minus 1.
- R10: stall and mem_valid fall in the cycle after the handshake of the last needed spill or fill.
- R11: A call with 8 saved frames, or a return with none, pulses err high for one cycle and leaves base, frame size and the saved stack unchanged.
- R12: Base pointers and renamed indices wrap around modulo 64, including during spills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | 2 | Command: 0 none, 1 call, 2 allocate, 3 return |
| cmd_size | input | 7 | Requested frame size for allocate (values above 64 saturate) |
| lk_vreg | input | 7 | Virtual register number to rename |
| lk_preg | output | 6 | Physical index of lk_vreg |
| lk_hit | output | 1 | lk_vreg lies in the current frame and no stall is in progress |
| stall | output | 1 | Spill or fill in progress; commands and lookups are refused |
| err | output | 1 | One-cycle pulse: call on full saved stack or return on empty one |
| mem_valid | output | 1 | Transfer request pending |
| mem_write | output | 1 | 1 = spill (register to store), 0 = fill (store to register) |
| mem_addr | output | 10 | Backing-store slot of the transfer |
| mem_preg | output | 6 | Physical register index of the transfer |
| mem_ready | input | 1 | Responder accepts the pending request |

## Verification
A wrong resident-register count or store top does not show at the moment it goes wrong. It shows at the next overflow or underflow: the transfer count is wrong, the first mem_preg or mem_addr of the burst is wrong, or stall falls early or late. Each of these is visible at the ports within the burst that follows. A wrong saved base or size shows in the first lookup after the return, because lk_preg or lk_hit no longer matches the caller's frame. Throttling ready during bursts shows whether a stalled request drifts or a handshake is counted twice.

// File: rtl/rse_pkg.sv
package rse_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_CALL  = 2'd1,
    OP_ALLOC = 2'd2,
    OP_RET   = 2'd3
  } rse_op_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SPILL = 2'd1,
    XS_FILL  = 2'd2
  } rse_xs_e;

endpackage

// File: rtl/rse_frame_stack.sv
// LIFO of saved caller (base, size) pairs.
module rse_frame_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 6,
  parameter int SW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] push_base,
  input  logic [SW-1:0] push_size,
  output logic [PW-1:0] top_base,
  output logic [SW-1:0] top_size,
  output logic          full,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] base_q [DEPTH];
  logic [SW-1:0] size_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;
  logic [IW-1:0] top_idx;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign cnt_m1  = cnt_q - 1'b1;
  assign top_idx = empty ? '0 : cnt_m1[IW-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end else if (push && !full && (cnt_q == CW'(i))) begin
        base_q[i] <= push_base;
        size_q[i] <= push_size;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (push && !full)    cnt_q <= cnt_q + 1'b1;
    else if (pop && !empty)    cnt_q <= cnt_q - 1'b1;
  end

  assign top_base = base_q[top_idx];
  assign top_size = size_q[top_idx];
endmodule

// File: rtl/rse_rename.sv
// Virtual-to-physical register index translation through the frame base.
module rse_rename #(
  parameter int PHYS = 64,
  parameter int PW   = 6,
  parameter int SW   = 7
) (
  input  logic [PW-1:0] base,
  input  logic [SW-1:0] size,
  input  logic          blocked,
  input  logic [SW-1:0] vreg,
  output logic [PW-1:0] preg,
  output logic          hit
);
  logic [SW-1:0] v_fold;
  logic [SW:0]   sum;
  logic [SW:0]   wrapped;

  always_comb begin
    v_fold  = (vreg >= SW'(PHYS)) ? vreg - SW'(PHYS) : vreg;
    sum     = (SW+1)'(base) + (SW+1)'(v_fold);
    wrapped = (sum >= (SW+1)'(PHYS)) ? sum - (SW+1)'(PHYS) : sum;
  end

  assign preg = wrapped[PW-1:0];
  assign hit  = !blocked && (vreg < size);
endmodule

// File: rtl/rse_xfer_seq.sv
// Spill/fill sequencer: one register per valid/ready handshake.
module rse_xfer_seq import rse_pkg::*; #(
  parameter int PHYS = 64,
  parameter int PW   = 6,
  parameter int SW   = 7,
  parameter int AW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_spill,
  input  logic          start_fill,
  input  logic [SW-1:0] start_cnt,
  input  logic [PW-1:0] start_preg,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          fire,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] mem_preg,
  input  logic          mem_ready
);
  rse_xs_e       st_q;
  logic [SW-1:0] rem_q;
  logic [PW-1:0] preg_q;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] preg_up;
  logic [PW-1:0] preg_dn;

  assign busy      = (st_q != XS_IDLE);
  assign mem_valid = busy;
  assign mem_write = (st_q == XS_SPILL);
  assign mem_addr  = addr_q;
  assign mem_preg  = preg_q;
  assign fire      = mem_valid && mem_ready;

  always_comb begin
    preg_up = (preg_q == PW'(PHYS - 1)) ? '0 : preg_q + 1'b1;
    preg_dn = (preg_q == '0) ? PW'(PHYS - 1) : preg_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      rem_q  <= '0;
      preg_q <= '0;
      addr_q <= '0;
    end else begin
      case (st_q)
        XS_IDLE: begin
          if ((start_spill || start_fill) && (start_cnt != '0)) begin
            st_q   <= start_spill ? XS_SPILL : XS_FILL;
            rem_q  <= start_cnt;
            preg_q <= start_preg;
            addr_q <= start_addr;
          end
        end
        XS_SPILL, XS_FILL: begin
          if (fire) begin
            rem_q <= rem_q - 1'b1;
            if (st_q == XS_SPILL) begin
              preg_q <= preg_up;
              addr_q <= addr_q + 1'b1;
            end else begin
              preg_q <= preg_dn;
              addr_q <= addr_q - 1'b1;
            end
            if (rem_q == SW'(1)) st_q <= XS_IDLE;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rse_engine.sv
// Register stack frame engine top.
module rse_engine import rse_pkg::*; #(
  parameter  int PHYS   = 64,
  parameter  int DEPTH  = 8,
  parameter  int MEM_AW = 10,
  localparam int PW     = $clog2(PHYS),
  localparam int SW     = $clog2(PHYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [SW-1:0]     cmd_size,
  input  logic [SW-1:0]     lk_vreg,
  output logic [PW-1:0]     lk_preg,
  output logic              lk_hit,
  output logic              stall,
  output logic              err,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [PW-1:0]     mem_preg,
  input  logic              mem_ready
);
  logic [PW-1:0]     bof_q;
  logic [SW-1:0]     sof_q;
  logic [SW-1:0]     ndirty_q;
  logic [MEM_AW-1:0] mtop_q;
  logic              err_q;

  rse_op_e       op;
  logic          go;
  logic          call_ok, ret_ok, alloc_go, bad_cmd;
  logic [SW-1:0] req;
  logic [SW-1:0] room;
  logic          need_spill;
  logic [SW-1:0] spill_cnt;
  logic [PW-1:0] spill_first;
  logic [PW-1:0] call_base;
  logic          need_fill;
  logic [SW-1:0] deficit;
  logic [PW-1:0] fill_first;
  logic          busy, fire;

  logic          stk_full, stk_empty;
  logic [PW-1:0] top_base;
  logic [SW-1:0] top_size;

  function automatic logic [PW-1:0] mod_phys(input logic [SW:0] s);
    logic [SW:0] t;
    t = (s >= (SW+1)'(PHYS)) ? s - (SW+1)'(PHYS) : s;
    return t[PW-1:0];
  endfunction

  always_comb begin
    op        = rse_op_e'(cmd_op);
    go        = !busy;
    call_ok   = go && (op == OP_CALL) && !stk_full;
    ret_ok    = go && (op == OP_RET) && !stk_empty;
    alloc_go  = go && (op == OP_ALLOC);
    bad_cmd   = go && (((op == OP_CALL) && stk_full) || ((op == OP_RET) && stk_empty));

    req        = (cmd_size > SW'(PHYS)) ? SW'(PHYS) : cmd_size;
    room       = SW'(PHYS) - ndirty_q;
    need_spill = alloc_go && (req > room);
    spill_cnt  = req - room;
    // oldest resident caller register sits ndirty below the base
    spill_first = mod_phys((SW+1)'(bof_q) + (SW+1)'(PHYS) - (SW+1)'(ndirty_q));

    call_base  = mod_phys((SW+1)'(bof_q) + (SW+1)'(sof_q));

    need_fill  = ret_ok && (top_size > ndirty_q);
    deficit    = top_size - ndirty_q;
    fill_first = mod_phys((SW+1)'(top_base) + (SW+1)'(deficit) + (SW+1)'(PHYS - 1));
  end

  rse_frame_stack #(.DEPTH(DEPTH), .PW(PW), .SW(SW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (call_ok),
    .pop       (ret_ok),
    .push_base (bof_q),
    .push_size (sof_q),
    .top_base  (top_base),
    .top_size  (top_size),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  rse_xfer_seq #(.PHYS(PHYS), .PW(PW), .SW(SW), .AW(MEM_AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_spill (need_spill),
    .start_fill  (need_fill),
    .start_cnt   (need_spill ? spill_cnt : deficit),
    .start_preg  (need_spill ? spill_first : fill_first),
    .start_addr  (need_spill ? mtop_q : mtop_q - 1'b1),
    .busy        (busy),
    .fire        (fire),
    .mem_valid   (mem_valid),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_preg    (mem_preg),
    .mem_ready   (mem_ready)
  );

  rse_rename #(.PHYS(PHYS), .PW(PW), .SW(SW)) u_ren (
    .base    (bof_q),
    .size    (sof_q),
    .blocked (busy),
    .vreg    (lk_vreg),
    .preg    (lk_preg),
    .hit     (lk_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bof_q    <= '0;
      sof_q    <= '0;
      ndirty_q <= '0;
      mtop_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= bad_cmd;
      if (fire) begin
        if (mem_write) begin
          ndirty_q <= ndirty_q - 1'b1;
          mtop_q   <= mtop_q + 1'b1;
        end else begin
          mtop_q   <= mtop_q - 1'b1;
        end
      end else if (call_ok) begin
        bof_q    <= call_base;
        ndirty_q <= ndirty_q + sof_q;
        sof_q    <= '0;
      end else if (alloc_go) begin
        sof_q    <= req;
      end else if (ret_ok) begin
        bof_q    <= top_base;
        sof_q    <= top_size;
        ndirty_q <= need_fill ? '0 : ndirty_q - top_size;
      end
    end
  end

  assign stall = busy;
  assign err   = err_q;
endmodule

// File: rtl/rse_engine_chk.sv
module rse_engine_chk import rse_pkg::*; #(
  parameter int PW = 6,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmd_op,
  input logic          stall,
  input logic          err,
  input logic          lk_hit,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [PW-1:0] mem_preg
);
  a_r3_call_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cmd_op == 2'(OP_CALL)) |=> !stall);

  a_r6_stall_hides_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !lk_hit);

  a_r7_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_preg) && $stable(mem_write)));

  a_r11_err_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !stall);

  a_r5_alloc_never_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cmd_op == 2'(OP_ALLOC)) |=> !(mem_valid && !mem_write));
endmodule

bind rse_engine rse_engine_chk #(.PW(PW), .AW(MEM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_op    (cmd_op),
  .stall     (stall),
  .err       (err),
  .lk_hit    (lk_hit),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_preg  (mem_preg)
);

// File: tb/tb_rse_engine.sv
`timescale 1ns/1ps
module tb_rse_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_size = '0;
  logic [6:0] lk_vreg = '0;
  logic [5:0] lk_preg;
  logic       lk_hit, stall, err, mem_valid, mem_write;
  logic [9:0] mem_addr;
  logic [5:0] mem_preg;
  logic       mem_ready = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rse_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_size(cmd_size),
    .lk_vreg(lk_vreg), .lk_preg(lk_preg), .lk_hit(lk_hit),
    .stall(stall), .err(err), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_preg(mem_preg), .mem_ready(mem_ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_op = 2'd0; mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input int op, input int sz);
    @(negedge clk);
    cmd_op = 2'(op); cmd_size = 7'(sz);
    @(negedge clk);
    cmd_op = 2'd0; cmd_size = '0;
  endtask

  task automatic look(input int v, input int exp_hit, input int exp_preg, input string tag);
    lk_vreg = 7'(v);
    #1;
    check({tag, " hit"}, lk_hit, exp_hit);
    if (exp_hit != 0) check({tag, " preg"}, lk_preg, exp_preg);
  endtask

  task automatic run_xfer(input int n, input int p0, input int a0, input bit up, input string tag);
    int k = 0;
    int cyc = 0;
    while (k < n) begin
      mem_ready = ((cyc % 3) != 2);
      #1;
      check({tag, " R7 valid held"}, mem_valid, 1);
      if (mem_ready) begin
        check({tag, " preg"}, mem_preg, up ? (p0 + k) % 64 : (p0 - k + 64) % 64);
        check({tag, " addr"}, mem_addr, up ? a0 + k : a0 - k);
        check({tag, " dir"}, mem_write, up ? 1 : 0);
        check({tag, " R6 stall during burst"}, stall, 1);
        k++;
      end
      cyc++;
      @(negedge clk);
    end
    mem_ready = 1'b0;
    #1;
    check({tag, " R10 stall falls"}, stall, 0);
    check({tag, " R10 valid falls"}, mem_valid, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 stall", stall, 0);
    check("R1 err", err, 0);
    check("R1 mem_valid", mem_valid, 0);
    look(0, 0, 0, "R1 empty frame");
  endtask

  task automatic t_spill_fill();
    do_reset();
    issue(2, 10);
    check("R4 no stall", stall, 0);
    look(3, 1, 3, "R2 v3");
    look(10, 0, 0, "R2 v10 outside");
    issue(1, 0);
    check("R3 call no stall", stall, 0);
    check("R3 call no request", mem_valid, 0);
    look(0, 0, 0, "R3 empty callee");
    mem_ready = 1'b0;
    issue(2, 60);
    check("R5 stall raised", stall, 1);
    look(0, 0, 0, "R6 lookup during stall");
    issue(2, 1);
    run_xfer(6, 0, 0, 1'b1, "R5 spill");
    look(59, 1, 5, "R12 wrap / R6 ignored alloc");
    look(0, 1, 10, "R3 callee base");
    issue(3, 0);
    check("R9 stall on underflow", stall, 1);
    run_xfer(6, 5, 5, 1'b0, "R9 fill");
    look(9, 1, 9, "R8 caller frame back");
    look(10, 0, 0, "R8 caller size");
  endtask

  task automatic t_resident_return();
    do_reset();
    issue(2, 5);
    issue(1, 0);
    issue(2, 3);
    look(0, 1, 5, "R3 base moved by 5");
    issue(3, 0);
    check("R8 no stall", stall, 0);
    check("R8 no request", mem_valid, 0);
    look(4, 1, 4, "R8 base restored");
    look(5, 0, 0, "R8 size restored");
  endtask

  task automatic t_stack_limits();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      issue(1, 0);
      check("R11 call within depth", err, 0);
    end
    issue(1, 0);
    check("R11 full call err", err, 1);
    @(negedge clk);
    check("R11 err one cycle", err, 0);
    issue(2, 2);
    look(1, 1, 1, "R11 base unchanged");
    for (int i = 0; i < 8; i++) begin
      issue(3, 0);
      check("R11 return within depth", err, 0);
    end
    issue(3, 0);
    check("R11 empty return err", err, 1);
  endtask

  task automatic t_wrap_spill();
    do_reset();
    issue(2, 40);
    issue(1, 0);
    issue(2, 20);
    check("R4 fits free", stall, 0);
    look(19, 1, 59, "R2 v19");
    issue(1, 0);
    mem_ready = 1'b0;
    issue(2, 10);
    check("R5 stall raised", stall, 1);
    run_xfer(6, 0, 0, 1'b1, "R5 oldest-first spill");
    look(5, 1, 1, "R12 renamed wrap");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_spill_fill();
    t_resident_return();
    t_stack_limits();
    t_wrap_spill();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule